// File: doc/BRIEF.md
# Factorial Register Unit

A memory-mapped register slave on a simple 32-bit read/write bus. It holds an identification word, a liveness register and a factorial register. The liveness register returns the bitwise inverse of the value last written, so a driver can confirm that the unit is present and responding.

Writing an operand to the factorial register starts an iterative computation. The computation does one multiply per clock. When it finishes, the result replaces the operand in the same register. A status register exposes a read-only busy flag and a writable completion-interrupt enable. When the enable is set, the end of a computation sends a one-cycle set request to a separate interrupt status block.

Each bus request is valid for one cycle. A read returns its data on the next cycle. The bus carries an access size in bytes.

Top module: `mmr_fact_unit`

## Requirements
- R1: Offset 0x00 reads `{VER_MAJOR, VER_MINOR, 8'h00, 8'hED}`, most significant byte first (0x010000ED by default). Writes to it have no effect.
- R2: Offset 0x04 reads back the bitwise complement of the last value written to it. It reads 0 after reset.
- R3: A read request makes `rsp_valid` high on the next cycle, carrying the data for that offset. Offsets other than 0x00, 0x04, 0x08 and 0x20 (including every offset of 0x80 and above) read 0, and writes to them are ignored. No response is produced for writes.
- R4: At offsets below 0x80, any access whose `req_size` is not 4 is ignored. A write of another size changes nothing. A read of another size returns 0.
- R5: A 4-byte write of n to 0x08 while idle starts a computation. Status bit 0 (busy) then reads 1 for max(n,1) cycles after the write cycle, and reads 0 afterwards.
- R6: While the unit is busy, 0x08 reads the operand. Once busy has cleared, it reads n! modulo 2^32.
- R7: An operand of 0 or of 1 yields a result of 1.
- R8: A write to 0x08 while busy is ignored. The running computation and its result are unaffected.
- R9: Status bit 7 is the completion-interrupt enable. It is read/write. The other status bits ignore writes, and bits other than 0 and 7 read 0.
- R10: With bit 7 set, the end of a computation raises `irq_set_valid` for exactly one cycle with `irq_set_value` = 0x00000001. The pulse comes in the first cycle in which busy reads 0. With bit 7 clear, no pulse is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Byte offset in the register window |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W (32) | Read data |
| irq_set_valid | output | 1 | Set request to the interrupt status block |
| irq_set_value | output | DATA_W (32) | Bits to set in the interrupt status |

## Verification
The bench polls the busy flag on every cycle after each start. This catches an off-by-one in the iteration count, including the degenerate operands 0 and 1, where a naive counter would finish immediately or would spin through a wrapped count.

A second write issued while busy must leave the result untouched. A design that restarted on that write would return 3! instead of 6!.

Operand 13 overflows 32 bits and must wrap rather than saturate. The interrupt pulse is timed against the cycle in which busy falls.

Wrong-size accesses and unmapped offsets must neither change the liveness register nor return stale data.

// File: rtl/mmr_pkg.sv
package mmr_pkg;
    localparam logic [6:0] OFF_ID   = 7'h00;
    localparam logic [6:0] OFF_LIVE = 7'h04;
    localparam logic [6:0] OFF_FACT = 7'h08;
    localparam logic [6:0] OFF_STAT = 7'h20;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_IEN_BIT  = 7;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_ID, SEL_LIVE, SEL_FACT, SEL_STAT
    } reg_sel_e;
endpackage

// File: rtl/mmr_decode.sv
module mmr_decode
    import mmr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    output reg_sel_e          sel
);
    logic low_window;

    always_comb begin
        low_window = (addr[ADDR_W-1:7] == '0);
        sel = SEL_NONE;
        if (low_window && size == 4'(WORD_BYTES)) begin
            case (addr[6:0])
                OFF_ID:   sel = SEL_ID;
                OFF_LIVE: sel = SEL_LIVE;
                OFF_FACT: sel = SEL_FACT;
                OFF_STAT: sel = SEL_STAT;
                default:  sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/fact_engine.sv
module fact_engine #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    typedef struct packed {
        logic              busy;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] acc;
    } eng_state_t;

    eng_state_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.cnt  = operand;
                d.acc  = DATA_W'(1);
            end
        end else if (q.cnt <= DATA_W'(1)) begin
            d.busy = 1'b0;
            done   = 1'b1;
        end else begin
            d.acc = q.acc * q.cnt;
            d.cnt = q.cnt - DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = q.busy;
    assign result = q.acc;

    // R5
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5
    done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/mmr_fact_unit.sv
module mmr_fact_unit
    import mmr_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter int          DATA_W    = 32,
    parameter logic [7:0]  VER_MAJOR = 8'h01,
    parameter logic [7:0]  VER_MINOR = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq_set_valid,
    output logic [DATA_W-1:0] irq_set_value
);
    localparam logic [DATA_W-1:0] ID_WORD  = DATA_W'({VER_MAJOR, VER_MINOR, 8'h00, 8'hED});
    localparam logic [DATA_W-1:0] IRQ_CODE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] live;
        logic [DATA_W-1:0] fact;
        logic              irq_en;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic              irq_valid;
    } top_state_t;

    top_state_t q, d;
    reg_sel_e   sel;
    logic       eng_start, eng_busy, eng_done;
    logic [DATA_W-1:0] eng_result, status_word;

    mmr_decode #(.ADDR_W(ADDR_W), .WORD_BYTES(DATA_W / 8)) u_decode (
        .addr (req_addr),
        .size (req_size),
        .sel  (sel)
    );

    fact_engine #(.DATA_W(DATA_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .operand (req_wdata),
        .busy    (eng_busy),
        .done    (eng_done),
        .result  (eng_result)
    );

    assign eng_start = req_valid && req_write && (sel == SEL_FACT) && !eng_busy;

    always_comb begin
        status_word = '0;
        status_word[STAT_BUSY_BIT] = eng_busy;
        status_word[STAT_IEN_BIT]  = q.irq_en;
    end

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.rsp_data  = '0;
        d.irq_valid = 1'b0;
        if (eng_done) begin
            d.fact      = eng_result;
            d.irq_valid = q.irq_en;
        end
        if (req_valid && !req_write) begin
            d.rsp_valid = 1'b1;
            case (sel)
                SEL_ID:   d.rsp_data = ID_WORD;
                SEL_LIVE: d.rsp_data = q.live;
                SEL_FACT: d.rsp_data = q.fact;
                SEL_STAT: d.rsp_data = status_word;
                default:  d.rsp_data = '0;
            endcase
        end
        if (req_valid && req_write) begin
            case (sel)
                SEL_LIVE: d.live = ~req_wdata;
                SEL_FACT: if (!eng_busy) d.fact = req_wdata;
                SEL_STAT: d.irq_en = req_wdata[STAT_IEN_BIT];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid     = q.rsp_valid;
    assign rsp_rdata     = q.rsp_data;
    assign irq_set_valid = q.irq_valid;
    assign irq_set_value = q.irq_valid ? IRQ_CODE : '0;

    // R3
    read_gets_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R3
    no_rsp_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R4
    bad_size_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(OFF_LIVE) && req_size != 4'(DATA_W / 8))
        |=> $stable(q.live));

    // R8
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && sel == SEL_FACT && eng_busy && !eng_done) |=> $stable(q.fact));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_valid |-> (irq_set_value == IRQ_CODE && !eng_busy));

    // R10
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_valid |=> !irq_set_valid);
endmodule

// File: tb/mmr_fact_unit_tb.sv
module mmr_fact_unit_tb;
    localparam int AW = 20;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_size = 4'd4;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid, irq_set_valid;
    logic [DW-1:0] rsp_rdata, irq_set_value;

    int n_checks = 0, n_fail = 0;
    int cyc = 0, last_wr_cyc = 0, irq_cnt = 0, last_irq_cyc = -1;
    bit finished = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    mmr_fact_unit u_dut (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
        .rsp_valid, .rsp_rdata, .irq_set_valid, .irq_set_value
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard entries as responses arrive, tracks irq pulses
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) check(0, "R3 unexpected response", rsp_rdata, '0);
            else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
        if (rst_n && irq_set_valid) begin
            irq_cnt++;
            last_irq_cyc = cyc;
            check(irq_set_value === 32'h1, "R10 irq value", irq_set_value, 32'h1);
        end
    end

    task automatic bus_read(logic [AW-1:0] a, logic [3:0] sz, logic [DW-1:0] e, string t);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_size = sz; req_wdata = '0;
        exp_q.push_back(e); tag_q.push_back(t);
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [3:0] sz, logic [DW-1:0] v);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = v;
        last_wr_cyc = cyc;
    endtask

    task automatic bus_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0; req_write = 0;
        end
    endtask

    function automatic logic [DW-1:0] fact_ref(int n);
        logic [DW-1:0] a = 1;
        for (int i = 2; i <= n; i++) a = a * DW'(i);
        return a;
    endfunction

    task automatic run_fact(int n, bit en);
        int m = (n < 2) ? 1 : n;
        int c0, cnt0;
        string rt = (n < 2) ? "R7 result" : "R6 result";
        cnt0 = irq_cnt;
        bus_write(20'h08, 4, DW'(n));
        c0 = last_wr_cyc;
        bus_read(20'h08, 4, DW'(n), "R6 operand while busy");
        for (int j = 2; j <= m + 1; j++)
            bus_read(20'h20, 4, {24'h0, en, 6'h0, (j <= m)}, "R5 busy window");
        bus_read(20'h08, 4, fact_ref(n), rt);
        bus_idle(4);
        check(irq_cnt == cnt0 + int'(en), "R10 irq count", DW'(irq_cnt - cnt0), DW'(en));
        if (en)
            check(last_irq_cyc == c0 + m + 1, "R10 irq timing", DW'(last_irq_cyc), DW'(c0 + m + 1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(rsp_valid === 0, "R3 reset rsp", DW'(rsp_valid), 0);
        check(irq_set_valid === 0, "R10 reset irq", DW'(irq_set_valid), 0);
        bus_read(20'h04, 4, 32'h0, "R2 reset live");
        bus_read(20'h08, 4, 32'h0, "R6 reset fact");
        bus_read(20'h20, 4, 32'h0, "R9 reset status");
        // R1 id and its write immunity
        bus_read(20'h00, 4, 32'h010000ED, "R1 id");
        bus_write(20'h00, 4, 32'hFFFFFFFF);
        bus_read(20'h00, 4, 32'h010000ED, "R1 id after write");
        // R2 liveness
        bus_write(20'h04, 4, 32'h12345678);
        bus_read(20'h04, 4, 32'hEDCBA987, "R2 live inverse");
        bus_write(20'h04, 4, 32'h0);
        bus_read(20'h04, 4, 32'hFFFFFFFF, "R2 live zero");
        // R4 wrong sizes
        bus_write(20'h04, 2, 32'h0000FFFF);
        bus_read(20'h04, 4, 32'hFFFFFFFF, "R4 size-2 write ignored");
        bus_read(20'h04, 2, 32'h0, "R4 size-2 read zero");
        bus_read(20'h04, 8, 32'h0, "R4 size-8 read zero");
        // R3 unmapped
        bus_write(20'h10, 4, 32'hA5A5A5A5);
        bus_read(20'h10, 4, 32'h0, "R3 unmapped low");
        bus_read(20'h80, 4, 32'h0, "R3 offset 0x80");
        bus_read(20'h04, 4, 32'hFFFFFFFF, "R3 live intact");
        // R9 status bits
        bus_write(20'h20, 4, 32'hFFFFFF7F);
        bus_read(20'h20, 4, 32'h0, "R9 other bits ignored");
        bus_write(20'h20, 4, 32'hFFFFFFFF);
        bus_read(20'h20, 4, 32'h80, "R9 enable set");
        bus_write(20'h20, 4, 32'h0);
        bus_read(20'h20, 4, 32'h0, "R9 enable cleared");
        bus_idle(2);
        // factorials
        run_fact(5, 0);
        run_fact(0, 0);
        bus_write(20'h20, 4, 32'h80);
        run_fact(1, 1);
        run_fact(13, 1);
        run_fact(10, 1);
        // R8 write during busy
        bus_write(20'h08, 4, 32'd6);
        bus_write(20'h08, 4, 32'd3);
        bus_idle(12);
        bus_read(20'h08, 4, 32'd720, "R8 busy write ignored");
        bus_idle(4);
        check(exp_q.size() == 0, "R3 all responses seen", DW'(exp_q.size()), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule